// File: doc/BRIEF.md
# Banked Extended RAM Access Port

This block sits behind a narrow 8-bit register bus and lets a host reach a RAM much larger than the bus's address space. At its base level it offers a small general-purpose RAM that is addressed directly by register offset. A bank-select bit in a control register remaps the upper half of the offset space, 0x40 to 0x7F, onto a second bank. That bank holds a split indirect address, a data port and a burst-enable control.

Host software programs the indirect address as two bytes and then reads or writes the data port. Each access of the data port reaches the extended RAM at the current indirect address. With burst enabled, every data-port access, read or write, advances the address by one. The address wraps at the end of the RAM, so a whole block can be streamed with no address writes in between. The size of the extended RAM is a parameter that takes a power of two from 128 to 8192 bytes.

Top module: `xram_port`

## Requirements
- R1: After reset the bank bit, the burst enable and both indirect address bytes are 0. A read of offset 0x0A returns 0x00, and with the bank selected, offsets 0x4A, 0x50 and 0x51 read 0x00.
- R2: Bit 4 of offset 0x0A is the bank bit (1 selects the extended bank). A read of 0x0A returns only that bit; every other bit reads 0.
- R3: Offsets 0x0E to 0x3F are general RAM in both banks. While the bank bit is 0, offsets 0x40 to 0x7F are also general RAM. Written bytes read back unchanged. Offsets 0x00 to 0x0D other than 0x0A, and offsets 0x80 to 0xFF, read 0x00.
- R4: In the extended bank, offset 0x50 holds the low address byte and offset 0x51 holds the high byte. The high byte reads back only the address bits the RAM implements (bits 2:0 for 2048 bytes), and its other bits read 0.
- R5: In the extended bank, a write of offset 0x53 stores the byte at the current indirect address, and a read of 0x53 returns the byte stored there.
- R6: Bit 5 of offset 0x4A in the extended bank is burst enable, and the register reads back only that bit. While burst enable is 1, each read or write of 0x53 increments the indirect address by one after the access.
- R7: While burst enable is 0, data-port accesses leave the indirect address unchanged.
- R8: The indirect address wraps modulo the RAM size: one increment from the last location gives address 0.
- R9: While the bank bit is 1, writes to the offsets from 0x40 to 0x7F that hold no extended register change nothing, and those offsets read 0x00. The general RAM at 0x40 to 0x7F keeps its contents for the next return to bank 0. A bank-0 write to 0x53 leaves the extended RAM and the indirect address unchanged.
- R10: Read data is presented on rd_data in the cycle after the cycle in which rd_en was sampled high.
- R11: Reset clears neither the general RAM nor the extended RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| offset | input | 8 | Register offset of the current access |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The checker assumes that the host never raises wr_en and rd_en in the same cycle, so that a data-port access is either a read or a write and an address-byte write can never coincide with an increment. It also assumes that rd_data is consulted only in the cycle right after a read strobe. The bench drives every access through tasks that pulse exactly one strobe for one cycle and then idle, and it samples the read data at the falling edge that follows the capturing edge. The bench sweeps all general RAM offsets and all 2048 extended locations in burst mode, and it covers the wrap point, the bank switches and a reset in the middle of the run.

// File: rtl/xram_pkg.sv
package xram_pkg;

  localparam logic [7:0] OFF_CTRL_A  = 8'h0A;
  localparam logic [7:0] OFF_EXT_CTL = 8'h4A;
  localparam logic [7:0] OFF_ADDR_LO = 8'h50;
  localparam logic [7:0] OFF_ADDR_HI = 8'h51;
  localparam logic [7:0] OFF_DATA    = 8'h53;

  localparam logic [7:0] GP_LOW_FIRST = 8'h0E;
  localparam logic [7:0] GP_LOW_LAST  = 8'h3F;
  localparam logic [7:0] UPPER_FIRST  = 8'h40;
  localparam logic [7:0] UPPER_LAST   = 8'h7F;

  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;

  localparam int GP_DEPTH = 128;

  typedef struct packed {
    logic ctrl_a;
    logic ext_ctl;
    logic addr_lo;
    logic addr_hi;
    logic data_port;
    logic gp;
  } xr_sel_t;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_GP  = 2'd1,
    SRC_XR  = 2'd2
  } xr_src_e;

endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
(
  input  logic [7:0] offset,
  input  logic       bank,
  output xr_sel_t    sel
);

  logic in_low_gp;
  logic in_upper;
  logic in_ext;

  always_comb begin
    in_low_gp     = (offset >= GP_LOW_FIRST) && (offset <= GP_LOW_LAST);
    in_upper      = (offset >= UPPER_FIRST) && (offset <= UPPER_LAST);
    in_ext        = in_upper && bank;
    sel.ctrl_a    = (offset == OFF_CTRL_A);
    sel.ext_ctl   = in_ext && (offset == OFF_EXT_CTL);
    sel.addr_lo   = in_ext && (offset == OFF_ADDR_LO);
    sel.addr_hi   = in_ext && (offset == OFF_ADDR_HI);
    sel.data_port = in_ext && (offset == OFF_DATA);
    sel.gp        = in_low_gp || (in_upper && !bank);
  end

endmodule

// File: rtl/xram_addr.sv
module xram_addr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          inc,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] addr,
  output logic [7:0]    lo_view,
  output logic [7:0]    hi_view
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic [15:0]   wide_q;

  assign wide_q  = 16'(addr_q);
  assign lo_view = wide_q[7:0];
  assign hi_view = wide_q[15:8];
  assign addr    = addr_q;

  // Byte writes win over an increment requested in the same cycle.
  always_comb begin
    addr_d = addr_q;
    if (wr_lo) begin
      addr_d = AW'({wide_q[15:8], wdata});
    end else if (wr_hi) begin
      addr_d = AW'({wdata, wide_q[7:0]});
    end else if (inc) begin
      addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_lo || wr_hi || inc) begin
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/xram_sram.sv
module xram_sram #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];
  logic [7:0] q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      q <= mem[addr];
    end
  end

  assign rdata = q;

endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int XRAM_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] offset,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rd_data
);

  localparam int ADDR_W = $clog2(XRAM_BYTES);
  localparam int GP_AW  = $clog2(GP_DEPTH);

  // Reset synchronizer: assert asynchronously, release on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // Control state
  logic    bank_q, bank_d;
  logic    burst_q, burst_d;
  xr_sel_t sel;

  xram_decode u_decode (
    .offset (offset),
    .bank   (bank_q),
    .sel    (sel)
  );

  always_comb begin
    bank_d  = bank_q;
    burst_d = burst_q;
    if (wr_en && sel.ctrl_a) begin
      bank_d = wdata[BANK_BIT];
    end
    if (wr_en && sel.ext_ctl) begin
      burst_d = wdata[BURST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      burst_q <= burst_d;
    end
  end

  // Indirect address
  logic              port_access;
  logic              addr_inc;
  logic [ADDR_W-1:0] xaddr;
  logic [7:0]        lo_view;
  logic [7:0]        hi_view;

  assign port_access = (wr_en || rd_en) && sel.data_port;
  assign addr_inc    = port_access && burst_q;

  xram_addr #(.AW(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_lo   (wr_en && sel.addr_lo),
    .wr_hi   (wr_en && sel.addr_hi),
    .inc     (addr_inc),
    .wdata   (wdata),
    .addr    (xaddr),
    .lo_view (lo_view),
    .hi_view (hi_view)
  );

  // Storage
  logic [7:0] gp_rdata;
  logic [7:0] xr_rdata;

  xram_sram #(.DEPTH(GP_DEPTH)) u_gp_ram (
    .clk   (clk),
    .we    (wr_en && sel.gp),
    .re    (rd_en && sel.gp),
    .addr  (offset[GP_AW-1:0]),
    .wdata (wdata),
    .rdata (gp_rdata)
  );

  xram_sram #(.DEPTH(XRAM_BYTES)) u_ext_ram (
    .clk   (clk),
    .we    (wr_en && sel.data_port),
    .re    (rd_en && sel.data_port),
    .addr  (xaddr),
    .wdata (wdata),
    .rdata (xr_rdata)
  );

  // Read path: capture a source and a register value on the strobe.
  logic [7:0] reg_val;
  logic [7:0] reg_q, reg_d;
  xr_src_e    src_q, src_d;

  always_comb begin
    reg_val = 8'h00;
    if (sel.ctrl_a) begin
      reg_val[BANK_BIT] = bank_q;
    end else if (sel.ext_ctl) begin
      reg_val[BURST_BIT] = burst_q;
    end else if (sel.addr_lo) begin
      reg_val = lo_view;
    end else if (sel.addr_hi) begin
      reg_val = hi_view;
    end
  end

  always_comb begin
    src_d = src_q;
    reg_d = reg_q;
    if (rd_en) begin
      reg_d = reg_val;
      if (sel.gp) begin
        src_d = SRC_GP;
      end else if (sel.data_port) begin
        src_d = SRC_XR;
      end else begin
        src_d = SRC_REG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q <= SRC_REG;
      reg_q <= 8'h00;
    end else if (rd_en) begin
      src_q <= src_d;
      reg_q <= reg_d;
    end
  end

  always_comb begin
    case (src_q)
      SRC_GP:  rd_data = gp_rdata;
      SRC_XR:  rd_data = xr_rdata;
      default: rd_data = reg_q;
    endcase
  end

endmodule

// File: rtl/xram_port_chk.sv
module xram_port_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    offset,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic          bank,
  input logic          burst,
  input logic [AW-1:0] addr
);

  logic [15:0] addr16;
  logic        port_hit;

  assign addr16   = 16'(addr);
  assign port_hit = bank && (offset == 8'h53) && (wr_en || rd_en);

  // Input assumption: one strobe at a time.
  a_in_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  // R1: state is cleared while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (!bank && !burst && (addr == '0));
    end
  end

  // R2: control register readback shows only the bank bit.
  a_r2_bank_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && offset == 8'h0A) |=> (rd_data == {3'b000, $past(bank), 4'b0000}));

  // R4: high address byte reads the implemented bits only.
  a_r4_hi_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bank && offset == 8'h51) |=> (rd_data == $past(addr16[15:8])));

  // R6, R8: burst access advances the address modulo the RAM size.
  a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && burst) |=> (addr == $past(addr) + AW'(1)));

  // R7: without burst the address holds across a data-port access.
  a_r7_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && !burst) |=> $stable(addr));

endmodule

bind xram_port xram_port_chk #(.AW(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .offset  (offset),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .bank    (bank_q),
  .burst   (burst_q),
  .addr    (xaddr)
);

// File: tb/xram_port_tb.sv
`timescale 1ns/1ps
module xram_port_tb;

  localparam int NBYTES = 2048;

  logic       clk;
  logic       rst_n;
  logic [7:0] offset;
  logic [7:0] wdata;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] rd_data;

  int checks;
  int errors;
  bit done;

  xram_port #(.XRAM_BYTES(NBYTES)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .offset  (offset),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] xpat(input int i);
    return 8'((i * 13) + (i >> 8) + 7);
  endfunction

  function automatic logic [7:0] gpat(input int o);
    return 8'((o * 37) + 5);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    offset = o; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R10: data is sampled one cycle after the strobe.
  task automatic rd(input logic [7:0] o, output logic [7:0] v);
    @(negedge clk);
    offset = o; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; offset = 8'h00; wdata = 8'h00; wr_en = 1'b0; rd_en = 1'b0;
    do_reset();

    // R1 reset values
    rd(8'h0A, v); chk("R1 ctrl after reset", v, 8'h00);
    wr(8'h0A, 8'h10);
    rd(8'h4A, v); chk("R1 burst after reset", v, 8'h00);
    rd(8'h50, v); chk("R1 addr lo after reset", v, 8'h00);
    rd(8'h51, v); chk("R1 addr hi after reset", v, 8'h00);

    // R2 bank bit readback
    wr(8'h0A, 8'hFF);
    rd(8'h0A, v); chk("R2 only bank bit", v, 8'h10);
    wr(8'h0A, 8'hEF);
    rd(8'h0A, v); chk("R2 bank cleared", v, 8'h00);
    wr(8'h0A, 8'h10);

    // R4 address bytes
    wr(8'h50, 8'hA5); wr(8'h51, 8'hFF);
    rd(8'h50, v); chk("R4 lo byte", v, 8'hA5);
    rd(8'h51, v); chk("R4 hi implemented bits", v, 8'h07);

    // R5 and R7 single access without burst
    wr(8'h50, 8'h23); wr(8'h51, 8'h01);
    wr(8'h53, 8'h5C);
    rd(8'h53, v); chk("R5 data port readback", v, 8'h5C);
    rd(8'h50, v); chk("R7 lo unchanged", v, 8'h23);
    rd(8'h51, v); chk("R7 hi unchanged", v, 8'h01);

    // R6 burst control readback
    wr(8'h4A, 8'hFF);
    rd(8'h4A, v); chk("R6 burst bit only", v, 8'h20);

    // R6 burst write sweep of the full RAM, R8 wrap back to 0
    wr(8'h50, 8'h00); wr(8'h51, 8'h00);
    for (int i = 0; i < NBYTES; i++) wr(8'h53, xpat(i));
    rd(8'h50, v); chk("R8 lo after full sweep", v, 8'h00);
    rd(8'h51, v); chk("R8 hi after full sweep", v, 8'h00);
    for (int i = 0; i < NBYTES; i++) begin
      rd(8'h53, v); chk("R6 burst read sweep", v, xpat(i));
    end
    rd(8'h51, v); chk("R8 hi after read sweep", v, 8'h00);

    // R8 explicit wrap at the last location
    wr(8'h50, 8'hFF); wr(8'h51, 8'h07);
    rd(8'h53, v); chk("R8 last location", v, xpat(NBYTES - 1));
    rd(8'h50, v); chk("R8 wrapped lo", v, 8'h00);
    rd(8'h51, v); chk("R8 wrapped hi", v, 8'h00);

    // R7 burst disabled: repeated reads stay put
    wr(8'h4A, 8'h00);
    wr(8'h50, 8'h05); wr(8'h51, 8'h00);
    rd(8'h53, v); chk("R7 read 1", v, xpat(5));
    rd(8'h53, v); chk("R7 read 2", v, xpat(5));
    rd(8'h50, v); chk("R7 lo held", v, 8'h05);

    // R3 general RAM sweep in bank 0
    wr(8'h0A, 8'h00);
    for (int o = 8'h0E; o <= 8'h7F; o++) wr(8'(o), gpat(o));
    for (int o = 8'h0E; o <= 8'h7F; o++) begin
      rd(8'(o), v); chk("R3 general RAM", v, gpat(o));
    end
    for (int o = 8'h00; o <= 8'h0D; o++) begin
      if (o != 8'h0A) begin
        rd(8'(o), v); chk("R3 unmapped low", v, 8'h00);
      end
    end
    rd(8'h80, v); chk("R3 unmapped high", v, 8'h00);
    rd(8'hFF, v); chk("R3 unmapped top", v, 8'h00);

    // R9 bank 1 hides the upper general RAM
    wr(8'h0A, 8'h10);
    for (int o = 8'h40; o <= 8'h7F; o++) begin
      if (o != 8'h4A && o != 8'h50 && o != 8'h51 && o != 8'h53) wr(8'(o), 8'hEE);
    end
    for (int o = 8'h40; o <= 8'h7F; o++) begin
      if (o != 8'h4A && o != 8'h50 && o != 8'h51 && o != 8'h53) begin
        rd(8'(o), v); chk("R9 empty bank offset", v, 8'h00);
      end
    end
    rd(8'h20, v); chk("R3 low RAM in bank 1", v, gpat(8'h20));
    rd(8'h50, v); chk("R9 addr lo untouched", v, 8'h05);
    wr(8'h0A, 8'h00);
    for (int o = 8'h40; o <= 8'h7F; o++) begin
      rd(8'(o), v); chk("R9 upper RAM kept", v, gpat(o));
    end
    wr(8'h53, 8'h99);
    wr(8'h0A, 8'h10);
    rd(8'h53, v); chk("R9 ext RAM untouched", v, xpat(5));
    rd(8'h50, v); chk("R9 addr after bank0 write", v, 8'h05);
    wr(8'h0A, 8'h00);
    rd(8'h53, v); chk("R9 bank0 0x53 is general", v, 8'h99);

    // R11 reset keeps RAM, R1 clears state again
    do_reset();
    rd(8'h0A, v); chk("R1 ctrl after second reset", v, 8'h00);
    rd(8'h20, v); chk("R11 general RAM kept", v, gpat(8'h20));
    wr(8'h0A, 8'h10);
    rd(8'h4A, v); chk("R1 burst after second reset", v, 8'h00);
    rd(8'h50, v); chk("R1 lo after second reset", v, 8'h00);
    rd(8'h53, v); chk("R11 ext RAM kept", v, xpat(0));
    wr(8'h50, 8'h0A);
    rd(8'h53, v); chk("R11 ext RAM kept at 10", v, xpat(10));

    finish_run();
  end

endmodule